// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is the slave end of a two-wire serial bus. It gives a bus master write and read access to a small bank of 8-bit control registers. A fast system clock oversamples the bus clock and data lines. The block finds START and STOP conditions on those lines and compares the first byte of each transfer with its 7-bit device address. The lowest address bit comes from a strap input, so two copies of the block can share one bus.

In a write transfer, the byte after the address loads a register pointer. Each later byte is stored at the pointer, and the pointer then steps on by one. Writing goes on until the master sends a STOP, and there is no limit on the number of bytes. In a read transfer, the block shifts out the register at the pointer and steps the pointer. It keeps doing this while the master acknowledges each byte. The block pulls the data line low through an output enable and never drives it high. The whole register bank is also presented as one parallel output vector, which the rest of the chip reads directly. The block has no flow-controlled stream interface: the bus master sets the pace, and the parallel vector is always valid.

The register count must be a power of two so that the pointer wraps. The system clock must run at least 20 times faster than the bus clock.

Top module: `twr_regbank_slave`

## Requirements
- R1: After reset, every register reads 0x00 and the data-line pull-down enable `sda_oe` is 0.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A STOP at any point, including partway through a byte, releases SDA and returns the block to waiting for a START; no partial byte is stored.
- R3: The device address is 7'b110000s, where s is `addr_strap`. With s=0 the address bytes 0xC0 (write) and 0xC1 (read) are acknowledged. With s=1 the bytes 0xC2 and 0xC3 are acknowledged.
- R4: An address byte that does not match gets no acknowledge. Every later byte up to the next START is ignored: no acknowledge, no drive and no register change.
- R5: Bytes are sent MSB first and sampled on the SCL rising edge, and a ninth clock carries the acknowledge. To acknowledge, the block pulls SDA low after the falling edge of the eighth clock. It keeps SDA low through the whole high phase of the ninth clock and releases it after that clock's falling edge.
- R6: In a write (bit 0 of the address byte is 0), the first data byte loads the pointer. Each later byte is stored at the pointer, acknowledged, and the pointer then increments. For example, pointer 0x00 followed by 0x0E, 0xD8 and 0xE1 leaves registers 0, 1 and 2 holding those values.
- R7: The pointer takes the low log2(NREG) bits of the pointer byte, which is bits [3:0] for 16 registers, and ignores the upper bits. The pointer wraps from NREG-1 to 0, in both writes and reads.
- R8: In a read (bit 0 of the address byte is 1), the block shifts out the register at the pointer, MSB first, changing SDA only while SCL is low. It then increments the pointer. When the master acknowledges (SDA low on the ninth clock), the next register follows.
- R9: A master NACK after a read byte makes the block release SDA and wait for a START. A START in the middle of a transfer (repeated START) releases SDA and restarts address matching while keeping the pointer.
- R10: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Selects the lowest bit of the device address |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| regs_flat | output | NREG*8 | Register bank, register k at bits [8k+7:8k] |

## Verification
The bench builds the block with its default parameters: 16 registers and a two-stage synchronizer. At this size the pointer wrap from register 15 to register 0 can be reached in a single short transfer, for both writes and reads. The bench clocks SCL at one fortieth of the system clock, so each bus phase gives the synchronizer and edge-detect latency enough margin. Toggling the strap between transfers exercises both address variants and the mismatch path against one instance.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_POINTER,
    ST_WRDATA,
    ST_RDDATA,
    ST_RDACK
  } twr_state_e;
endpackage

// File: rtl/twr_sync_edge.sv
module twr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // STAGES flops of synchronizer plus one history flop for edge detection
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/twr_reg_file.sv
module twr_reg_file #(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [IW-1:0]      rd_idx,
  output logic [7:0]         rd_data,
  output logic [NREG*8-1:0]  regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 q <= '0;
      else if (wr_en && wr_idx == IW'(g))         q <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = q;
  end

  assign rd_data = regs_flat[rd_idx*8 +: 8];
endmodule

// File: rtl/twr_xfer_fsm.sv
module twr_xfer_fsm
  import twr_pkg::*;
#(
  parameter int          NREG     = 16,
  parameter logic [5:0]  DEV_HIGH = 6'b110000,
  localparam int         IW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          strap,
  input  logic [7:0]    rd_data,
  output logic [IW-1:0] rd_idx,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  twr_state_e       state_q;
  logic [7:0]       shreg_q;
  logic [CNT_W-1:0] bitcnt_q;
  logic [IW-1:0]    ptr_q;
  logic             in_ack_q;
  logic             is_read_q;
  logic             more_q;
  logic             byte_full;
  logic             addr_hit;

  assign byte_full = (bitcnt_q == CNT_W'(BYTE_W));
  assign addr_hit  = (shreg_q[7:1] == {DEV_HIGH, strap});
  assign rd_idx    = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      shreg_q   <= '0;
      bitcnt_q  <= '0;
      ptr_q     <= '0;
      in_ack_q  <= 1'b0;
      is_read_q <= 1'b0;
      more_q    <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state_q  <= ST_IDLE;
        sda_oe   <= 1'b0;
        in_ack_q <= 1'b0;
      end else if (start_det) begin
        state_q  <= ST_DEVADR;
        bitcnt_q <= '0;
        sda_oe   <= 1'b0;
        in_ack_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DEVADR, ST_POINTER, ST_WRDATA: begin
            if (in_ack_q) begin
              if (scl_fall) begin
                sda_oe   <= 1'b0;
                in_ack_q <= 1'b0;
                bitcnt_q <= '0;
                if (state_q == ST_DEVADR) begin
                  if (is_read_q) begin
                    state_q <= ST_RDDATA;
                    shreg_q <= rd_data;
                    sda_oe  <= ~rd_data[7];
                  end else begin
                    state_q <= ST_POINTER;
                  end
                end else begin
                  state_q <= ST_WRDATA;
                end
              end
            end else if (scl_rise && !byte_full) begin
              shreg_q  <= {shreg_q[6:0], sda_lvl};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall && byte_full) begin
              if (state_q == ST_DEVADR) begin
                if (addr_hit) begin
                  is_read_q <= shreg_q[0];
                  sda_oe    <= 1'b1;
                  in_ack_q  <= 1'b1;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_POINTER) begin
                ptr_q    <= shreg_q[IW-1:0];
                sda_oe   <= 1'b1;
                in_ack_q <= 1'b1;
              end else begin
                wr_en    <= 1'b1;
                wr_idx   <= ptr_q;
                wr_data  <= shreg_q;
                ptr_q    <= ptr_q + 1'b1;
                sda_oe   <= 1'b1;
                in_ack_q <= 1'b1;
              end
            end
          end
          ST_RDDATA: begin
            if (scl_rise && !byte_full) begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall) begin
              if (byte_full) begin
                sda_oe  <= 1'b0;
                ptr_q   <= ptr_q + 1'b1;
                state_q <= ST_RDACK;
              end else begin
                shreg_q <= {shreg_q[6:0], 1'b0};
                sda_oe  <= ~shreg_q[6];
              end
            end
          end
          ST_RDACK: begin
            if (scl_rise) begin
              more_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (more_q) begin
                shreg_q  <= rd_data;
                sda_oe   <= ~rd_data[7];
                bitcnt_q <= '0;
                state_q  <= ST_RDDATA;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twr_regbank_slave.sv
module twr_regbank_slave #(
  parameter int          NREG        = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [5:0]  DEV_HIGH    = 6'b110000,
  localparam int         IW          = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_flat
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic wr_en;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [7:0]    wr_data, rd_data;

  twr_sync_edge #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  twr_sync_edge #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  // Bus conditions: data edge while clock is high
  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;

  twr_xfer_fsm #(.NREG(NREG), .DEV_HIGH(DEV_HIGH)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det), .strap(addr_strap),
    .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_oe(sda_oe)
  );

  twr_reg_file #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .regs_flat(regs_flat)
  );
endmodule

// File: rtl/twr_regbank_checker.sv
module twr_regbank_checker #(
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              start_det,
  input logic              stop_det,
  input logic              wr_en,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_flat
);
  logic [NREG-1:0] chg;
  logic [NREG*8-1:0] regs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_prev <= '0;
    else        regs_prev <= regs_flat;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_chg
    assign chg[g] = (regs_flat[g*8 +: 8] != regs_prev[g*8 +: 8]);
  end

  // R10: the pull-down enable moves only in the SCL low phase
  p_oe_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  // R2: STOP releases the data line
  p_stop_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R9: a (repeated) START releases the data line
  p_start_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R6: at most one register changes per cycle
  p_one_reg_per_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));

  // R5: every store coincides with an acknowledge being driven
  p_store_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_oe);
endmodule

bind twr_regbank_slave twr_regbank_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl),
  .start_det(start_det), .stop_det(stop_det),
  .wr_en(wr_en), .sda_oe(sda_oe), .regs_flat(regs_flat)
);

// File: tb/twr_regbank_slave_test.sv
`timescale 1ns/1ps
module twr_regbank_slave_test;
  localparam int NREG = 16;
  localparam int H    = 20;   // SCL half period in system clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] regs_flat;
  wire  sda_bus = sda_m & ~sda_oe;

  int vectors = 0;
  int errors  = 0;
  int cyc = 0;
  int upd_stamp = 0;
  bit done = 1'b0;
  logic [7:0] exp_regs [NREG];

  always #2.5 clk = ~clk;

  twr_regbank_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_strap(strap), .sda_oe(sda_oe), .regs_flat(regs_flat)
  );

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*8 +: 8] = exp_regs[k];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Per-clock comparison of the register bank against the model (R6, R7, R4)
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && (cyc - upd_stamp > 10))
      check(regs_flat == model_flat(), "R6 bank vs model", regs_flat, model_flat());
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // All bus tasks start and end at the middle of an SCL low phase (or idle).
  task automatic bus_start();
    sda_m = 1'b1; tick(H/2);
    scl_m = 1'b1; tick(H/2);
    sda_m = 1'b0; tick(H/2);
    scl_m = 1'b0; tick(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H/2);
    scl_m = 1'b1; tick(H/2);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b;    tick(H/2);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(H/2);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit wr,
                           input int idx, input bit chk_release, input string req);
    logic got_ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H/2);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0;
      if (i == 0 && wr) begin
        exp_regs[idx] = b;
        upd_stamp = cyc;
      end
      tick(H/2);
    end
    sda_m = 1'b1; tick(H/2);
    scl_m = 1'b1; tick(H/4);
    got_ack = ~sda_bus;
    tick(H/2);
    check((~sda_bus) == got_ack, {req, " ack held through high"}, ~sda_bus, got_ack);
    tick(H/4);
    check(got_ack == exp_ack, {req, " ack"}, got_ack, exp_ack);
    scl_m = 1'b0; tick(H/2);
    if (chk_release)
      check(sda_oe == 1'b0, "R5 release after ack", sda_oe, 1'b0);
  endtask

  task automatic recv_byte(input logic [7:0] expv, input bit m_ack, input string req);
    logic [7:0] got;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H/2);
      scl_m = 1'b1; tick(H/2);
      got[i] = sda_bus;
      tick(H/2);
      scl_m = 1'b0; tick(H/2);
    end
    check(got == expv, req, got, expv);
    bit_out(~m_ack);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NREG; k++) exp_regs[k] = 8'h00;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R1: reset state
    check(regs_flat == '0, "R1 regs after reset", regs_flat, 0);
    check(sda_oe == 1'b0, "R1 sda released", sda_oe, 1'b0);

    // R3, R6: strap low, write 0E D8 E1 from pointer 0
    strap = 1'b0; tick(4);
    bus_start();
    send_byte(8'hC0, 1'b1, 1'b0, 0, 1'b1, "R3 addr C0 strap0");
    send_byte(8'h00, 1'b1, 1'b0, 0, 1'b1, "R6 pointer");
    send_byte(8'h0E, 1'b1, 1'b1, 0, 1'b1, "R6 data0");
    send_byte(8'hD8, 1'b1, 1'b1, 1, 1'b1, "R6 data1");
    send_byte(8'hE1, 1'b1, 1'b1, 2, 1'b1, "R6 data2");
    bus_stop();
    check(regs_flat[23:0] == 24'hE1D80E, "R6 regs 0..2", regs_flat[23:0], 24'hE1D80E);

    // R4, R3: mismatched address ignored to the next START
    bus_start();
    send_byte(8'hC2, 1'b0, 1'b0, 0, 1'b1, "R4 addr C2 strap0 nack");
    send_byte(8'h05, 1'b0, 1'b0, 0, 1'b1, "R4 later byte ignored");
    send_byte(8'h77, 1'b0, 1'b0, 0, 1'b1, "R4 data ignored");
    bus_stop();
    check(regs_flat == model_flat(), "R4 regs unchanged", regs_flat, model_flat());

    // R3: strap high moves the address to C2/C3
    strap = 1'b1; tick(4);
    bus_start();
    send_byte(8'hC0, 1'b0, 1'b0, 0, 1'b1, "R3 addr C0 strap1 nack");
    bus_stop();
    // R7: upper pointer bits ignored, wrap 15 -> 0
    bus_start();
    send_byte(8'hC2, 1'b1, 1'b0, 0, 1'b1, "R3 addr C2 strap1");
    send_byte(8'h1F, 1'b1, 1'b0, 0, 1'b1, "R7 pointer 0x1F");
    send_byte(8'hAA, 1'b1, 1'b1, 15, 1'b1, "R7 data reg15");
    send_byte(8'hBB, 1'b1, 1'b1, 0, 1'b1, "R7 data wraps reg0");
    bus_stop();
    check(regs_flat[127:120] == 8'hAA, "R7 reg15", regs_flat[127:120], 8'hAA);
    check(regs_flat[7:0] == 8'hBB, "R7 reg0 after wrap", regs_flat[7:0], 8'hBB);

    // R2: STOP in the middle of an address byte aborts it
    bus_start();
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    bus_stop();
    check(sda_oe == 1'b0, "R2 released after partial byte", sda_oe, 1'b0);
    bus_start();
    send_byte(8'hC2, 1'b1, 1'b0, 0, 1'b1, "R2 addr after abort");
    send_byte(8'h05, 1'b1, 1'b0, 0, 1'b1, "R2 pointer");
    send_byte(8'h3C, 1'b1, 1'b1, 5, 1'b1, "R2 data reg5");
    bus_stop();
    check(regs_flat[47:40] == 8'h3C, "R2 reg5", regs_flat[47:40], 8'h3C);

    // R8, R9: set pointer, repeated START, read with ACKs then NACK
    strap = 1'b0; tick(4);
    bus_start();
    send_byte(8'hC0, 1'b1, 1'b0, 0, 1'b1, "R9 addr write");
    send_byte(8'h01, 1'b1, 1'b0, 0, 1'b1, "R8 pointer 1");
    bus_start();
    send_byte(8'hC1, 1'b1, 1'b0, 0, 1'b0, "R9 repeated START read addr");
    recv_byte(8'hD8, 1'b1, "R8 read reg1");
    recv_byte(8'hE1, 1'b1, "R8 read reg2 after increment");
    recv_byte(8'h00, 1'b0, "R8 read reg3");
    check(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 1'b0);
    send_byte(8'hFF, 1'b0, 1'b0, 0, 1'b1, "R9 idle after NACK");
    bus_stop();

    // R7, R8: read wraps from 15 to 0
    bus_start();
    send_byte(8'hC0, 1'b1, 1'b0, 0, 1'b1, "R7 addr write");
    send_byte(8'h0F, 1'b1, 1'b0, 0, 1'b1, "R7 pointer 15");
    bus_start();
    send_byte(8'hC1, 1'b1, 1'b0, 0, 1'b0, "R8 read addr");
    recv_byte(8'hAA, 1'b1, "R7 read reg15");
    recv_byte(8'hBB, 1'b0, "R7 read wraps reg0");
    bus_stop();

    // R3: read address with the wrong strap is not acknowledged
    bus_start();
    send_byte(8'hC3, 1'b0, 1'b0, 0, 1'b1, "R3 addr C3 strap0 nack");
    bus_stop();
    check(sda_oe == 1'b0, "R10 idle released", sda_oe, 1'b0);

    tick(20);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule